// File: doc/BRIEF.md
# Video Memory Block-Write Engine

This block is a synchronous model of a small video memory array made of 4-bit words. It also holds a 4-bit color register. Active-low row and column strobes and three control inputs are registered on the system clock. A falling strobe is found by comparing each sample with the one before it. The control levels seen when the row strobe falls decide what the whole row cycle does:

- **Refresh only:** no array change.
- **Page cycle:** normal column accesses.
- **Color register load:** the data pins go into the color register.
- **Flash write:** the color value goes into a whole row.
- **Transfer cycle:** not modelled, so it does nothing.

Inside a page cycle, each column strobe fall is one of three things: a read, a normal write, or a block write. The function-select level at that fall decides which. A block write fills up to four adjacent, aligned words with the color register value. The data pins choose which of the four columns are written. An optional per-bit mask, captured when the row strobe falls, chooses which bits are written. That mask stays fixed for the whole row cycle, including every page-mode column access.

Top module: `vram_blockwrite_engine`

## Requirements
- R1: After synchronous reset, `rd_vld` is 0, every array word is 0 and the color register is 0. A flash write issued straight after reset clears the words it touches.
- R2: In a page cycle, a column strobe fall with `func_sel` = 0 and `wr_n` = 0 writes `din` into the addressed word. With no mask active, all four bits are written.
- R3: In a page cycle, a column strobe fall with `func_sel` = 0 and `wr_n` = 1 is a read. `rd_data` then shows the addressed word, and `rd_vld` is high for exactly one cycle. That cycle follows the second rising clock edge at or after which `col_stb_n` is low.
- R4: A row strobe fall with `col_stb_n` = 1, `xfer_oe_n` = 1, `func_sel` = 1 and `wr_n` = 1 loads `din` into the color register.
- R5: A row strobe fall with `col_stb_n` = 1, `xfer_oe_n` = 1, `func_sel` = 1 and `wr_n` = 0 is a flash write. `addr` gives the row and `din` gives a bit mask. In every word of that row, each bit whose mask bit is 1 takes the color register bit, and each bit whose mask bit is 0 keeps its value. Other rows do not change.
- R6: In a page cycle, a column strobe fall with `func_sel` = 1 is a block write. The two low column address bits are treated as 0. Bit i of `din` enables column base+i, and columns whose bit is 0 do not change.
- R7: If `wr_n` was 1 at the row strobe fall, every enabled block-write column takes all four color register bits.
- R8: If `wr_n` was 0 at the row strobe fall, the `din` value at that fall becomes a bit mask. A mask bit of 1 lets that bit change; a mask bit of 0 keeps it. The mask applies to both block writes and normal writes.
- R9: The bit mask holds until the row strobe rises. Later `din` levels do not change it, and the next row cycle captures a fresh mask.
- R10: Reads, normal writes and block writes may be mixed in any order within one page cycle. Each column access follows the `func_sel` level at its own strobe fall.
- R11: A row strobe fall while `col_stb_n` is already low starts a refresh-only cycle. Column accesses in that cycle are ignored and the array does not change.
- R12: No array access happens while the row strobe is high. A row cycle opened with `xfer_oe_n` = 0 performs no reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write enable / mask-mode select, active low |
| xfer_oe_n | input | 1 | Transfer/output-enable control, active low |
| func_sel | input | 1 | Special-function select (color, flash, block write) |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 4 | Write data, column enables or bit mask |
| rd_data | output | 4 | Read data |
| rd_vld | output | 1 | Read data valid pulse |

## Verification
The hardest case to reach is a masked block write late in a long page cycle. It needs a row cycle opened in mask mode, then a block write, a read and a masked normal write in one page. After that comes a second block write whose `din` differs from the captured mask. Only then can the held mask be told apart from the current pin levels. The bench builds exactly that sequence on a row with mixed preloaded bits. It then opens a fresh unmasked row cycle on the same row to show that the mask was released.

// File: rtl/vram_pkg.sv
package vram_pkg;

    localparam int WORD_W = 4;
    localparam int GROUP  = 4;
    localparam int GRP_W  = $clog2(GROUP);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        RK_REFRESH,
        RK_PAGE,
        RK_COLOR,
        RK_FLASH,
        RK_XFER
    } row_kind_e;

    typedef enum logic [1:0] {
        MD_IDLE,
        MD_PAGE,
        MD_HOLD
    } mode_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_BLOCK,
        OP_FLASH
    } op_e;

    typedef struct packed {
        op_e   kind;
        word_t data;
        word_t sel;
        word_t bmask;
    } op_t;

    // Row-cycle classification from control levels at the row strobe fall.
    function automatic row_kind_e decode_row(logic cas_n, logic oe_n,
                                             logic we_n, logic fsel);
        row_kind_e k;
        if (!cas_n)
            k = RK_REFRESH;
        else if (!oe_n)
            k = RK_XFER;
        else if (fsel)
            k = we_n ? RK_COLOR : RK_FLASH;
        else
            k = RK_PAGE;
        return k;
    endfunction

    // Bits with a 1 in keep_mask take the new value.
    function automatic word_t merge_bits(word_t old_w, word_t new_w, word_t m);
        return (old_w & ~m) | (new_w & m);
    endfunction

endpackage

// File: rtl/vram_pin_sync.sv
module vram_pin_sync
    import vram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_n,
    input  logic              xfer_oe_n,
    input  logic              func_sel,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             din,
    output logic              s_ras_n,
    output logic              s_cas_n,
    output logic              s_we_n,
    output logic              s_oe_n,
    output logic              s_fsel,
    output logic [ADDR_W-1:0] s_addr,
    output word_t             s_din,
    output logic              ras_fall,
    output logic              cas_fall
);

    logic p_ras_n;
    logic p_cas_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_ras_n <= 1'b1;
            s_cas_n <= 1'b1;
            s_we_n  <= 1'b1;
            s_oe_n  <= 1'b1;
            s_fsel  <= 1'b0;
            s_addr  <= '0;
            s_din   <= '0;
            p_ras_n <= 1'b1;
            p_cas_n <= 1'b1;
        end else begin
            s_ras_n <= row_stb_n;
            s_cas_n <= col_stb_n;
            s_we_n  <= wr_n;
            s_oe_n  <= xfer_oe_n;
            s_fsel  <= func_sel;
            s_addr  <= addr;
            s_din   <= din;
            p_ras_n <= s_ras_n;
            p_cas_n <= s_cas_n;
        end
    end

    assign ras_fall = p_ras_n & ~s_ras_n;
    assign cas_fall = p_cas_n & ~s_cas_n;

endmodule

// File: rtl/vram_cycle_ctrl.sv
module vram_cycle_ctrl
    import vram_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_ras_n,
    input  logic              s_cas_n,
    input  logic              s_we_n,
    input  logic              s_oe_n,
    input  logic              s_fsel,
    input  logic [ADDR_W-1:0] s_addr,
    input  word_t             s_din,
    input  logic              ras_fall,
    input  logic              cas_fall,
    output op_t               op,
    output logic [ROW_W-1:0]  op_row,
    output logic [COL_W-1:0]  op_col
);

    mode_e             mode_q;
    logic [ROW_W-1:0]  row_q;
    word_t             mask_q;
    word_t             color_q;
    row_kind_e         rk;

    assign rk = decode_row(s_cas_n, s_oe_n, s_we_n, s_fsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MD_IDLE;
            row_q   <= '0;
            mask_q  <= '1;
            color_q <= '0;
        end else if (ras_fall) begin
            mode_q <= MD_HOLD;
            case (rk)
                RK_PAGE: begin
                    mode_q <= MD_PAGE;
                    row_q  <= s_addr[ROW_W-1:0];
                    mask_q <= s_we_n ? '1 : s_din;
                end
                RK_COLOR: color_q <= s_din;
                default: ;
            endcase
        end else if (s_ras_n) begin
            mode_q <= MD_IDLE;
        end
    end

    always_comb begin
        op       = '0;
        op.kind  = OP_NONE;
        op_row   = row_q;
        op_col   = s_addr[COL_W-1:0];
        if (ras_fall && rk == RK_FLASH) begin
            op.kind  = OP_FLASH;
            op.data  = color_q;
            op.bmask = s_din;
            op_row   = s_addr[ROW_W-1:0];
        end else if (cas_fall && !s_ras_n && mode_q == MD_PAGE) begin
            op.bmask = mask_q;
            if (s_fsel) begin
                op.kind = OP_BLOCK;
                op.data = color_q;
                op.sel  = s_din;
            end else if (!s_we_n) begin
                op.kind = OP_WRITE;
                op.data = s_din;
            end else begin
                op.kind = OP_READ;
            end
        end
    end

    // R1
    color_rst_chk: assert property (@(posedge clk) rst |=> (color_q == '0));

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_fall |=> $stable(mask_q));

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_HOLD) |-> (op.kind == OP_NONE));

endmodule

// File: rtl/vram_array.sv
module vram_array
    import vram_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_low,
    input  op_t              op,
    input  logic [ROW_W-1:0] op_row,
    input  logic [COL_W-1:0] op_col,
    output word_t            rd_data,
    output logic             rd_vld
);

    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    word_t mem [ROWS][COLS];
    logic [COL_W-1:0] lane_col [GROUP];

    for (genvar g = 0; g < GROUP; g++) begin : g_lane
        assign lane_col[g] = {op_col[COL_W-1:GRP_W], GRP_W'(g)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    mem[r][c] <= '0;
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= 1'b0;
            case (op.kind)
                OP_READ: begin
                    rd_data <= mem[op_row][op_col];
                    rd_vld  <= 1'b1;
                end
                OP_WRITE:
                    mem[op_row][op_col] <=
                        merge_bits(mem[op_row][op_col], op.data, op.bmask);
                OP_BLOCK:
                    for (int i = 0; i < GROUP; i++)
                        if (op.sel[i])
                            mem[op_row][lane_col[i]] <=
                                merge_bits(mem[op_row][lane_col[i]], op.data, op.bmask);
                OP_FLASH:
                    for (int c = 0; c < COLS; c++)
                        mem[op_row][c] <= merge_bits(mem[op_row][c], op.data, op.bmask);
                default: ;
            endcase
        end
    end

    // R12
    no_access_ras_high_chk: assert property (@(posedge clk) disable iff (rst)
        (op.kind != OP_NONE) |-> ras_low);

    // R3
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (op.kind == OP_READ) |=> rd_vld);

    // R3
    read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_vld |=> !rd_vld);

endmodule

// File: rtl/vram_blockwrite_engine.sv
module vram_blockwrite_engine
    import vram_pkg::*;
#(
    parameter int  ROW_W  = 4,
    parameter int  COL_W  = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_n,
    input  logic              xfer_oe_n,
    input  logic              func_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        din,
    output logic [3:0]        rd_data,
    output logic              rd_vld
);

    logic              s_ras_n, s_cas_n, s_we_n, s_oe_n, s_fsel;
    logic [ADDR_W-1:0] s_addr;
    word_t             s_din;
    logic              ras_fall, cas_fall;
    op_t               op;
    logic [ROW_W-1:0]  op_row;
    logic [COL_W-1:0]  op_col;

    vram_pin_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst(rst),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n), .wr_n(wr_n),
        .xfer_oe_n(xfer_oe_n), .func_sel(func_sel), .addr(addr), .din(din),
        .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
        .s_oe_n(s_oe_n), .s_fsel(s_fsel), .s_addr(s_addr), .s_din(s_din),
        .ras_fall(ras_fall), .cas_fall(cas_fall)
    );

    vram_cycle_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .s_ras_n(s_ras_n), .s_cas_n(s_cas_n), .s_we_n(s_we_n),
        .s_oe_n(s_oe_n), .s_fsel(s_fsel), .s_addr(s_addr), .s_din(s_din),
        .ras_fall(ras_fall), .cas_fall(cas_fall),
        .op(op), .op_row(op_row), .op_col(op_col)
    );

    vram_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
        .clk(clk), .rst(rst), .ras_low(~s_ras_n),
        .op(op), .op_row(op_row), .op_col(op_col),
        .rd_data(rd_data), .rd_vld(rd_vld)
    );

endmodule

// File: tb/sim_vram_blockwrite_engine.sv
`timescale 1ns/1ps
module sim_vram_blockwrite_engine;

    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       row_stb_n = 1'b1, col_stb_n = 1'b1, wr_n = 1'b1;
    logic       xfer_oe_n = 1'b1, func_sel = 1'b0;
    logic [3:0] addr = '0, din = '0;
    logic [3:0] rd_data;
    logic       rd_vld;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    logic [3:0] model [ROWS][COLS];
    logic [3:0] mcolor;

    always #2 clk = ~clk;

    vram_blockwrite_engine #(.ROW_W(ROW_W), .COL_W(COL_W)) u0 (
        .clk(clk), .rst(rst), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .wr_n(wr_n), .xfer_oe_n(xfer_oe_n), .func_sel(func_sel),
        .addr(addr), .din(din), .rd_data(rd_data), .rd_vld(rd_vld)
    );

    function automatic logic [3:0] mrg(logic [3:0] o, logic [3:0] n, logic [3:0] m);
        return (o & ~m) | (n & m);
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ras_open(int row, bit we, bit oe, bit fs, logic [3:0] d);
        @(negedge clk);
        addr = 4'(row); wr_n = we; xfer_oe_n = oe; func_sel = fs; din = d;
        row_stb_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ras_close();
        @(negedge clk);
        row_stb_n = 1'b1; col_stb_n = 1'b1; wr_n = 1'b1;
        func_sel = 1'b0; xfer_oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cas_pulse(int col, bit we, bit fs, logic [3:0] d,
                             output logic v1, output logic [3:0] q, output logic v2);
        @(negedge clk);
        addr = 4'(col); wr_n = we; func_sel = fs; din = d; col_stb_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        v1 = rd_vld; q = rd_data;
        @(negedge clk);
        v2 = rd_vld;
        col_stb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_word(int row, int col, logic [3:0] d);
        logic v1, v2; logic [3:0] q;
        ras_open(row, 1, 1, 0, 4'h0);
        cas_pulse(col, 0, 0, d, v1, q, v2);
        ras_close();
        model[row][col] = d;
    endtask

    task automatic expect_word(int row, int col, string req);
        logic v1, v2; logic [3:0] q;
        ras_open(row, 1, 1, 0, 4'h0);
        cas_pulse(col, 1, 0, 4'h0, v1, q, v2);
        ras_close();
        chk(req, q, model[row][col]);
    endtask

    task automatic set_color(logic [3:0] c);
        ras_open(0, 1, 1, 1, c);
        ras_close();
        mcolor = c;
    endtask

    task automatic flash(int row, logic [3:0] m);
        ras_open(row, 0, 1, 1, m);
        ras_close();
        for (int c = 0; c < COLS; c++) model[row][c] = mrg(model[row][c], mcolor, m);
    endtask

    task automatic t_reset();
        chk("R1 rd_vld after reset", {3'b0, rd_vld}, 4'h0);
        expect_word(0, 0, "R1 array zero");
        write_word(2, 0, 4'hF);
        write_word(2, 9, 4'h5);
        flash(2, 4'hF);
        expect_word(2, 0, "R1 color zero col0");
        expect_word(2, 9, "R1 color zero col9");
    endtask

    task automatic t_normal();
        logic v1, v2; logic [3:0] q;
        write_word(3, 1, 4'hA);
        write_word(3, 2, 4'h5);
        write_word(3, 15, 4'hC);
        expect_word(3, 1, "R2 write col1");
        expect_word(3, 2, "R2 write col2");
        expect_word(3, 15, "R2 write col15");
        ras_open(3, 1, 1, 0, 4'h0);
        cas_pulse(15, 1, 0, 4'h0, v1, q, v2);
        ras_close();
        chk("R3 read data", q, 4'hC);
        chk("R3 valid high", {3'b0, v1}, 4'h1);
        chk("R3 valid one cycle", {3'b0, v2}, 4'h0);
    endtask

    task automatic t_color_flash();
        set_color(4'hA);
        flash(4, 4'hF);
        expect_word(4, 0, "R4 R5 flash col0");
        expect_word(4, 15, "R5 flash col15");
        write_word(5, 3, 4'h5);
        flash(5, 4'h3);
        expect_word(5, 3, "R5 masked flash col3");
        expect_word(5, 0, "R5 masked flash col0");
        expect_word(6, 0, "R5 other row kept");
    endtask

    task automatic t_block();
        logic v1, v2; logic [3:0] q;
        set_color(4'h6);
        write_word(6, 6, 4'h9);
        write_word(6, 3, 4'hF);
        write_word(6, 8, 4'hF);
        ras_open(6, 1, 1, 0, 4'h0);
        cas_pulse(5, 1, 1, 4'b1011, v1, q, v2);
        ras_close();
        model[6][4] = mcolor; model[6][5] = mcolor; model[6][7] = mcolor;
        expect_word(6, 4, "R6 R7 block col4");
        expect_word(6, 5, "R7 block col5");
        expect_word(6, 6, "R6 unselected col6");
        expect_word(6, 7, "R6 block col7");
        expect_word(6, 3, "R6 below group");
        expect_word(6, 8, "R6 above group");
    endtask

    task automatic t_masked_page();
        logic v1, v2; logic [3:0] q;
        logic [3:0] m = 4'b0101;
        write_word(7, 0, 4'hF);
        write_word(7, 12, 4'hF);
        ras_open(7, 0, 1, 0, m);
        cas_pulse(0, 1, 1, 4'b0011, v1, q, v2);
        model[7][0] = mrg(model[7][0], mcolor, m);
        model[7][1] = mrg(model[7][1], mcolor, m);
        cas_pulse(1, 1, 0, 4'h0, v1, q, v2);
        chk("R10 read in mixed page", q, model[7][1]);
        cas_pulse(8, 0, 0, 4'hF, v1, q, v2);
        model[7][8] = mrg(model[7][8], 4'hF, m);
        cas_pulse(13, 1, 1, 4'b0011, v1, q, v2);
        model[7][12] = mrg(model[7][12], mcolor, m);
        model[7][13] = mrg(model[7][13], mcolor, m);
        ras_close();
        expect_word(7, 0, "R8 masked block col0");
        expect_word(7, 1, "R8 masked block col1");
        expect_word(7, 8, "R8 masked normal write");
        expect_word(7, 12, "R9 mask held col12");
        expect_word(7, 13, "R9 mask held col13");
        expect_word(7, 2, "R8 unselected col2");
        ras_open(7, 1, 1, 0, 4'h0);
        cas_pulse(0, 1, 1, 4'b0001, v1, q, v2);
        ras_close();
        model[7][0] = mcolor;
        expect_word(7, 0, "R9 mask released");
    endtask

    task automatic t_refresh();
        write_word(8, 2, 4'h3);
        @(negedge clk);
        col_stb_n = 1'b0;
        @(negedge clk);
        addr = 4'd8; wr_n = 1'b0; func_sel = 1'b1; din = 4'hF; row_stb_n = 1'b0;
        repeat (3) @(negedge clk);
        row_stb_n = 1'b1;
        @(negedge clk);
        col_stb_n = 1'b1; wr_n = 1'b1; func_sel = 1'b0;
        repeat (2) @(negedge clk);
        expect_word(8, 2, "R11 refresh keeps col2");
        expect_word(8, 0, "R11 refresh keeps col0");
    endtask

    task automatic t_ignored();
        logic v1, v2; logic [3:0] q;
        @(negedge clk);
        addr = 4'd9; wr_n = 1'b0; din = 4'hF; col_stb_n = 1'b0;
        repeat (3) @(negedge clk);
        col_stb_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_word(9, 9, "R12 cas with row high");
        ras_open(9, 1, 0, 0, 4'h0);
        cas_pulse(9, 1, 0, 4'h0, v1, q, v2);
        chk("R12 no read in transfer row", {3'b0, v1}, 4'h0);
        cas_pulse(9, 0, 0, 4'hF, v1, q, v2);
        ras_close();
        expect_word(9, 9, "R12 no write in transfer row");
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                model[r][c] = 4'h0;
        mcolor = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_normal();
        t_color_flash();
        t_block();
        t_masked_page();
        t_refresh();
        t_ignored();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule